// File: doc/BRIEF.md
# Three-Wire Serial Memory Slave

This block is the slave end of a three-wire serial memory link. It watches a chip-select, a serial clock and a serial data input, and it answers on a data output with an enable, so that data-out can be tri-stated. A host frames each transfer by raising chip select. It then sends a start bit, a two-bit opcode and an address. A write also carries one data word. The block keeps a small byte array whose size is set by a parameter. The organisation input selects whether that array is seen as 8-bit or 16-bit words.

All serial inputs are sampled by the block's own system clock. A serial-clock rising edge is found by comparing the input with its value one clock earlier. The host must therefore hold each level of the serial clock for at least two system clocks.

Programming is blocked by a write-enable latch. The latch is cleared by reset and changes only on explicit enable and disable commands. A read answers with one dummy zero and then the addressed word. While chip select stays high, the read keeps streaming words from the following addresses.

Top module: `mw_eeprom`

## Requirements
- R1: After reset, the output enable `so_en` is low, the write-enable latch is clear and every byte of the array reads as zero.
- R2: A WRITE received while the write-enable latch is clear leaves the array unchanged.
- R3: Enable is start bit 1, opcode 00, then the two most significant address bits 11, with the remaining address bits ignored. Disable is the same frame with 00 in those two bits. After enable, WRITE frames take effect. After disable, they are ignored again.
- R4: READ returns the stored data whether the write-enable latch is set or clear.
- R5: READ is start bit 1, opcode 10 and the address. The address is `ADDR_BITS` bits wide when `org16` is high and `ADDR_BITS+1` bits wide when it is low, and is sent MSB first. The response is one 0 bit followed by the word, MSB first. The word is 16 bits when `org16` is high and 8 bits when it is low.
- R6: WRITE is start bit 1, opcode 01, the address, then one word, all MSB first. In 16-bit organisation, the word at address a occupies byte 2a (upper half) and byte 2a+1 (lower half), and those are the same bytes that 8-bit organisation addresses as 2a and 2a+1.
- R7: While chip select stays high after a word, the next address follows with no dummy bit. The address wraps from the last address of the current organisation to 0.
- R8: `so_en` is low while chip select is low and while a command is being shifted in. It rises on the clock edge that accepts the last address bit of a READ.
- R9: Zeros before the start bit are ignored. Dropping chip select discards a partial command. A WRITE is committed only once chip select falls, and only if all of its data bits arrived.
- R10: `so_data` changes only in response to a rising edge of `sck`. It holds its value while `sck` is high and through the following low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| org16 | input | 1 | Word organisation: 1 = 16-bit words, 0 = 8-bit words |
| cs | input | 1 | Chip select, active high |
| sck | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data in |
| so_data | output | 1 | Serial data out |
| so_en | output | 1 | Drive enable for serial data out; low means high impedance |

## Verification
The hardest state to reach from the ports is a sequential read that crosses the top of the address space. It takes a read of several words started near the last address, and the wrap point depends on the organisation. Directed reads are therefore started at the final address in both organisations, and random reads of one to three words start at random addresses. A second hard case is a write cut short by chip select, because nothing at the ports shows the discarded data. The bench sends half a data word, drops select, and then reads the location back.

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
  parameter int ADDR_BITS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic org16,
  input  logic cs,
  input  logic sck,
  input  logic di,
  output logic so_data,
  output logic so_en
);
  localparam int AMAX   = ADDR_BITS + 1;
  localparam int NBYTES = 2 ** AMAX;
  localparam int SRW    = AMAX + 2;
  localparam int CW     = $clog2(SRW + 17);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_RD, S_WDAT, S_DONE} st_t;

  st_t             st;
  logic            sck_q;
  logic [SRW-2:0]  sr;
  logic [CW-1:0]   cnt;
  logic [AMAX-1:0] addr;
  logic [15:0]     wdat;
  logic [3:0]      idx;
  logic            wen, wr_pend, wr_org;
  logic [7:0]      mem [NBYTES];

  wire rise   = cs & sck & ~sck_q;
  wire mem_we = ~cs & wr_pend & wen;

  wire [SRW-1:0]  full  = {sr, di};
  wire [CW-1:0]   aw    = org16 ? CW'(ADDR_BITS) : CW'(ADDR_BITS + 1);
  wire [3:0]      wtop  = org16 ? 4'd15 : 4'd7;
  wire [1:0]      op    = org16 ? full[AMAX:AMAX-1] : full[AMAX+1:AMAX];
  wire [1:0]      top2  = org16 ? full[AMAX-2:AMAX-3] : full[AMAX-1:AMAX-2];
  wire [AMAX-1:0] cmd_a = org16 ? {1'b0, full[AMAX-2:0]} : full[AMAX-1:0];
  wire [AMAX-1:0] nxt_a = org16 ? {1'b0, addr[AMAX-2:0] + 1'b1} : addr + 1'b1;
  wire [AMAX-1:0] rd_b  = org16 ? {addr[AMAX-2:0], ~idx[3]} : addr;
  wire            rd_bit = mem[rd_b][idx[2:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      sr      <= '0;
      cnt     <= '0;
      addr    <= '0;
      wdat    <= '0;
      idx     <= '0;
      wen     <= 1'b0;
      wr_pend <= 1'b0;
      wr_org  <= 1'b0;
      so_data <= 1'b0;
      so_en   <= 1'b0;
    end else if (!cs) begin
      st      <= S_IDLE;
      sr      <= '0;
      cnt     <= '0;
      wr_pend <= 1'b0;
      so_en   <= 1'b0;
    end else if (rise) begin
      case (st)
        S_IDLE: if (di) begin
          st  <= S_CMD;
          sr  <= '0;
          cnt <= '0;
        end
        S_CMD: begin
          sr  <= full[SRW-2:0];
          cnt <= cnt + 1'b1;
          if (cnt == aw + 1'b1) begin
            addr <= cmd_a;
            cnt  <= '0;
            case (op)
              2'b10: begin
                st      <= S_RD;
                so_en   <= 1'b1;
                so_data <= 1'b0;
                idx     <= wtop;
              end
              2'b01: begin
                st     <= S_WDAT;
                wr_org <= org16;
              end
              2'b00: begin
                st <= S_DONE;
                if (top2 == 2'b11) wen <= 1'b1;
                if (top2 == 2'b00) wen <= 1'b0;
              end
              default: st <= S_DONE;
            endcase
          end
        end
        S_RD: begin
          so_data <= rd_bit;
          if (idx == 4'd0) begin
            addr <= nxt_a;
            idx  <= wtop;
          end else begin
            idx <= idx - 1'b1;
          end
        end
        S_WDAT: begin
          wdat <= {wdat[14:0], di};
          cnt  <= cnt + 1'b1;
          if (cnt == CW'(wtop)) begin
            wr_pend <= 1'b1;
            st      <= S_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTES; i++) mem[i] <= '0;
    end else if (mem_we) begin
      if (wr_org) begin
        mem[{addr[AMAX-2:0], 1'b0}] <= wdat[15:8];
        mem[{addr[AMAX-2:0], 1'b1}] <= wdat[7:0];
      end else begin
        mem[addr] <= wdat[7:0];
      end
    end
  end
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic sck,
  input logic so_en,
  input logic so_data,
  input logic wen,
  input logic mem_we
);
  AST_HIZ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> !so_en); // R8
  AST_DUMMY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(so_en) |-> !so_data); // R5
  AST_DOUT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (so_en && $past(so_en) && !$stable(so_data)) |-> ($past(sck) && !$past(sck, 2))); // R10
  AST_WEN_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wen) |-> ($past(cs) && $past(sck))); // R3
  AST_COMMIT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (!cs && $past(cs))); // R9
endmodule

bind mw_eeprom mw_eeprom_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .sck(sck),
  .so_en(so_en), .so_data(so_data), .wen(wen), .mem_we(mem_we)
);

// File: tb/test_mw_eeprom.sv
module test_mw_eeprom;
  localparam int CLK_PERIOD = 10;
  localparam int AB = 4;
  localparam int NB = 2 ** (AB + 1);

  logic clk = 1'b0, rst_n = 1'b0, org16 = 1'b0, cs = 1'b0, sck = 1'b0, di = 1'b0;
  logic so_data, so_en;
  int checks = 0, fails = 0;
  logic [7:0] mdl [NB];
  logic wen_m = 1'b0;

  mw_eeprom #(.ADDR_BITS(AB)) i_mw_eeprom (
    .clk(clk), .rst_n(rst_n), .org16(org16), .cs(cs), .sck(sck), .di(di),
    .so_data(so_data), .so_en(so_en)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int aw(input logic o);
    return o ? AB : AB + 1;
  endfunction
  function automatic int dw(input logic o);
    return o ? 16 : 8;
  endfunction
  function automatic int nwords(input logic o);
    return o ? 2 ** AB : 2 ** (AB + 1);
  endfunction
  function automatic logic [15:0] mword(input logic o, input int a);
    return o ? {mdl[2 * a], mdl[2 * a + 1]} : {8'h00, mdl[a]};
  endfunction

  task automatic bit_x(input logic b, output logic o, output logic oe);
    @(negedge clk) di = b;
    repeat (2) @(negedge clk);
    sck = 1'b1;
    repeat (2) @(negedge clk);
    o = so_data;
    oe = so_en;
    sck = 1'b0;
    repeat (2) @(negedge clk);
    if (oe) chk("R10", {31'd0, so_data}, {31'd0, o});
  endtask

  task automatic send(input logic [31:0] v, input int n);
    logic o, oe;
    for (int i = n - 1; i >= 0; i--) bit_x(v[i], o, oe);
  endtask

  task automatic cs_on();
    @(negedge clk) cs = 1'b1;
    repeat (2) @(negedge clk);
  endtask
  task automatic cs_off();
    @(negedge clk) cs = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_ewen(input logic o);
    org16 = o;
    cs_on();
    send(32'b10011 << (aw(o) - 2), 3 + aw(o));
    cs_off();
    wen_m = 1'b1;
  endtask
  task automatic do_ewds(input logic o);
    org16 = o;
    cs_on();
    send(32'b100 << aw(o), 3 + aw(o));
    cs_off();
    wen_m = 1'b0;
  endtask

  task automatic do_write(input logic o, input int a, input logic [15:0] d);
    org16 = o;
    cs_on();
    send((32'b101 << aw(o)) | a, 3 + aw(o));
    send({16'd0, d}, dw(o));
    cs_off();
    if (wen_m) begin
      if (o) begin
        mdl[2 * a] = d[15:8];
        mdl[2 * a + 1] = d[7:0];
      end else mdl[a] = d[7:0];
    end
  endtask

  task automatic do_read(input logic o, input int a, input int n, input string req);
    logic [31:0] hdr;
    logic b, oe;
    logic [15:0] w;
    org16 = o;
    cs_on();
    hdr = (32'b110 << aw(o)) | a;
    for (int i = 2 + aw(o); i >= 0; i--) begin
      bit_x(hdr[i], b, oe);
      if (i == 2 + aw(o)) chk("R8", {31'd0, oe}, 32'd0);
    end
    chk("R8", {31'd0, oe}, 32'd1);
    chk("R5", {31'd0, b}, 32'd0);
    for (int k = 0; k < n; k++) begin
      w = '0;
      for (int j = 0; j < dw(o); j++) begin
        bit_x(1'b0, b, oe);
        w = {w[14:0], b};
      end
      chk(req, {16'd0, w}, {16'd0, mword(o, (a + k) % nwords(o))});
    end
    cs_off();
    chk("R8", {31'd0, so_en}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic b, oe;
    for (int i = 0; i < NB; i++) mdl[i] = 8'h00;
    void'($urandom(32'h1d5e_3a77));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", {31'd0, so_en}, 32'd0);
    do_read(1'b0, 5, 1, "R1");

    do_write(1'b0, 5, 16'h00a5);
    do_read(1'b0, 5, 1, "R2");

    do_ewen(1'b0);
    do_write(1'b0, 5, 16'h005a);
    do_read(1'b0, 5, 1, "R3");
    do_write(1'b1, 3, 16'hbeef);
    do_read(1'b0, 6, 2, "R6");
    do_read(1'b1, 3, 1, "R5");
    do_write(1'b0, NB - 1, 16'h0081);
    do_write(1'b0, 0, 16'h0042);
    do_read(1'b0, NB - 1, 3, "R7");
    do_read(1'b1, 2 ** AB - 1, 2, "R7");

    org16 = 1'b0;
    cs_on();
    send(32'b101 << aw(1'b0) | 9, 3 + aw(1'b0));
    send(32'hf, 4);
    cs_off();
    do_read(1'b0, 9, 1, "R9");

    org16 = 1'b0;
    cs_on();
    send(32'b000, 3);
    send((32'b110 << aw(1'b0)) | 5, 3 + aw(1'b0));
    bit_x(1'b0, b, oe);
    chk("R9", {31'd0, oe}, 32'd1);
    cs_off();

    do_ewds(1'b1);
    do_write(1'b1, 3, 16'h1234);
    do_read(1'b1, 3, 1, "R4");

    for (int it = 0; it < 70; it++) begin
      int k;
      logic o;
      int a;
      logic [15:0] d;
      k = $urandom_range(0, 9);
      o = 1'($urandom_range(0, 1));
      a = $urandom_range(0, nwords(o) - 1);
      d = 16'($urandom);
      if (k == 0) do_ewen(o);
      else if (k == 1) do_ewds(o);
      else if (k < 6) do_write(o, a, d);
      else do_read(o, a, $urandom_range(1, 3), "R4");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule